// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 24-bit virtual address into a 16-bit physical address by reading a two-level page table out of a byte-wide memory. A requester presents the virtual address, an access kind (read or write), a privilege flag (user or kernel) and a start strobe. The walker fetches the first-level entry and then, if that entry permits the access, the second-level entry. Each 16-bit entry arrives as two byte reads, most significant byte first.

A walk ends with a one-cycle completion pulse and a 2-bit status. On success the status is 0, the physical address joins the leaf entry's page number with the untouched page offset, and the leaf entry's flag byte is returned. A walk stops at whichever level first meets an unusable entry. It reports either a missing mapping (status 1) or a mapping that forbids this access (status 2). The walker does one walk at a time. It never writes the table, and it does not keep earlier translations.

Top module: `pt_walker`

## Requirements
- R1: A walk first reads the byte at `tbl_base + 2 * req_vaddr[23:16]` (16-bit wrap) and then the byte at the next address. Every memory read is shown by `mem_rd_en` high for one cycle with `mem_addr`.
- R2: An entry is big-endian. The first byte read gives entry bits 15:8 (the page number), and the second byte gives bits 7:0 (the flags).
- R3: After a usable first-level entry with page number P, the walker reads the second-level entry at `{P, 8'h00} + 2 * req_vaddr[15:8]` (16-bit wrap), high byte first.
- R4: A successful walk reports status 0, `paddr = {leaf page number, req_vaddr[7:0]}` and `leaf_flags` = the leaf entry's low byte.
- R5: A clear valid bit (flag bit 0) at either level gives status 1. The walk stops at that level, with no second-level reads after a first-level fault, and `paddr` and `leaf_flags` read 0.
- R6: A write (`req_write`=1) that meets an entry whose write-enable bit (flag bit 1) is clear gives status 2. This check applies at both levels.
- R7: A user access (`req_user`=1) that meets an entry whose kernel-only bit (flag bit 7) is set gives status 2. This check applies at both levels. An invalid entry reports status 1 whatever its other bits are.
- R8: Read data returns one cycle after the read is issued. `done` is a one-cycle pulse: the 6th cycle after the start is sampled for a full walk, or the 4th for a first-level fault. Status 3 never appears.
- R9: The uncacheable (bit 6), dirty (bit 3) and use (bit 2) flags play no part in the outcome.
- R10: A start strobe that arrives while a walk is in progress is dropped. The running walk finishes with its own result, and no second walk follows.
- R11: While reset is held, `done`, `status`, `paddr`, `leaf_flags` and `mem_rd_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Begin a walk (sampled only while idle) |
| req_vaddr | input | 24 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| tbl_base | input | 16 | Byte address of the first-level table |
| mem_rd_en | output | 1 | Byte read request |
| mem_addr | output | 16 | Byte read address |
| mem_rdata | input | 8 | Read data, valid the cycle after the request |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 invalid page, 2 access violation |
| paddr | output | 16 | Translated physical address |
| leaf_flags | output | 8 | Flag byte of the leaf entry |

## Verification
Some properties are checked on every cycle. `done` never lasts two cycles and never carries status 3. A successful result always passes the offset through and shows a valid flag byte that agrees with the access kind and privilege. An error result always carries zeroed address and flags. The second byte of each entry is always read at the address just after the first. A latched request never changes mid-walk. Only the bench's scenarios can show the rest, because they need table contents: the exact fetch addresses at each level, which level stopped a walk, the precedence of invalid over violation, that the don't-care flags are ignored, and that a start dropped during a walk causes no reads.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_L1_HI = 3'd1,
    S_L1_LO = 3'd2,
    S_L2_HI = 3'd3,
    S_L2_LO = 3'd4,
    S_FIN   = 3'd5
  } walk_state_e;

  localparam logic [1:0] ST_OK        = 2'd0;
  localparam logic [1:0] ST_INVALID   = 2'd1;
  localparam logic [1:0] ST_VIOLATION = 2'd2;

  // flag byte bit positions
  localparam int FLG_VALID  = 0;
  localparam int FLG_WRITE  = 1;
  localparam int FLG_KERNEL = 7;

  // outcome of one entry's flag byte for a given access
  function automatic logic [1:0] judge_entry(input logic [7:0] flg,
                                             input logic is_write,
                                             input logic is_user);
    logic [1:0] res;
    res = ST_OK;
    if (!flg[FLG_VALID])                  res = ST_INVALID;
    else if (is_write && !flg[FLG_WRITE]) res = ST_VIOLATION;
    else if (is_user && flg[FLG_KERNEL])  res = ST_VIOLATION;
    return res;
  endfunction

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int AW = 16,
  parameter int IW = 8
) (
  input  logic [AW-1:0] tbl_base,
  input  logic [IW-1:0] index,
  output logic [AW-1:0] hi_addr,
  output logic [AW-1:0] lo_addr
);
  localparam int EW = IW + 1;

  logic [EW-1:0] byte_off;

  always_comb begin
    byte_off = {index, 1'b0};
    hi_addr  = tbl_base + AW'(byte_off);
    lo_addr  = hi_addr + AW'(1);
  end
endmodule

// File: rtl/ptw_entry_check.sv
module ptw_entry_check
  import ptw_pkg::*;
(
  input  logic [7:0] flg,
  input  logic       is_write,
  input  logic       is_user,
  output logic [1:0] verdict,
  output logic       fault
);
  always_comb begin
    verdict = judge_entry(flg, is_write, is_user);
    fault   = (verdict != ST_OK);
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int VA_W  = 24,
  parameter int PA_W  = 16,
  parameter int OFF_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_start,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic            req_write,
  input  logic            req_user,
  input  logic [PA_W-1:0] tbl_base,
  output logic            mem_rd_en,
  output logic [PA_W-1:0] mem_addr,
  input  logic [7:0]      mem_rdata,
  output logic            done,
  output logic [1:0]      status,
  output logic [PA_W-1:0] paddr,
  output logic [7:0]      leaf_flags
);
  localparam int IDX_W = (VA_W - OFF_W) / 2;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int L1_LSB = OFF_W + IDX_W;

  walk_state_e     state;
  logic [VA_W-1:0] vaddr_q;
  logic            wr_q, usr_q;
  logic [PA_W-1:0] base_q;
  logic [PPN_W-1:0] hi_q;
  logic            done_q;
  logic [1:0]      status_q;
  logic [PA_W-1:0] paddr_q;
  logic [7:0]      flags_q;

  // named internal events
  logic            accept_start;
  logic            entry_fault;
  logic [1:0]      entry_verdict;
  logic            l1_fault_stop;
  logic            l2_finish_ok;
  logic [PA_W-1:0] l1_hi_addr, l1_lo_addr, l2_hi_addr, l2_lo_addr;
  logic [PA_W-1:0] l2_base;

  assign accept_start  = (state == S_IDLE) && req_start;
  assign l2_base       = {hi_q, {OFF_W{1'b0}}};
  assign l1_fault_stop = (state == S_L2_HI) && entry_fault;
  assign l2_finish_ok  = (state == S_FIN) && !entry_fault;

  ptw_addr_gen #(.AW(PA_W), .IW(IDX_W)) u_l1_addr (
    .tbl_base (base_q),
    .index    (vaddr_q[VA_W-1:L1_LSB]),
    .hi_addr  (l1_hi_addr),
    .lo_addr  (l1_lo_addr)
  );

  ptw_addr_gen #(.AW(PA_W), .IW(IDX_W)) u_l2_addr (
    .tbl_base (l2_base),
    .index    (vaddr_q[L1_LSB-1:OFF_W]),
    .hi_addr  (l2_hi_addr),
    .lo_addr  (l2_lo_addr)
  );

  // the low byte on the data bus is judged in L2_HI (level 1) and FIN (level 2)
  ptw_entry_check u_check (
    .flg      (mem_rdata),
    .is_write (wr_q),
    .is_user  (usr_q),
    .verdict  (entry_verdict),
    .fault    (entry_fault)
  );

  always_comb begin
    mem_rd_en = 1'b0;
    mem_addr  = '0;
    unique case (state)
      S_L1_HI: begin mem_rd_en = 1'b1; mem_addr = l1_hi_addr; end
      S_L1_LO: begin mem_rd_en = 1'b1; mem_addr = l1_lo_addr; end
      S_L2_HI: begin mem_rd_en = !entry_fault; mem_addr = l2_hi_addr; end
      S_L2_LO: begin mem_rd_en = 1'b1; mem_addr = l2_lo_addr; end
      default: begin mem_rd_en = 1'b0; mem_addr = '0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      vaddr_q  <= '0;
      wr_q     <= 1'b0;
      usr_q    <= 1'b0;
      base_q   <= '0;
      hi_q     <= '0;
      done_q   <= 1'b0;
      status_q <= ST_OK;
      paddr_q  <= '0;
      flags_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (accept_start) begin
            vaddr_q <= req_vaddr;
            wr_q    <= req_write;
            usr_q   <= req_user;
            base_q  <= tbl_base;
            state   <= S_L1_HI;
          end
        end
        S_L1_HI: state <= S_L1_LO;
        S_L1_LO: begin
          hi_q  <= mem_rdata;
          state <= S_L2_HI;
        end
        S_L2_HI: begin
          if (l1_fault_stop) begin
            done_q   <= 1'b1;
            status_q <= entry_verdict;
            paddr_q  <= '0;
            flags_q  <= '0;
            state    <= S_IDLE;
          end else begin
            state <= S_L2_LO;
          end
        end
        S_L2_LO: begin
          hi_q  <= mem_rdata;
          state <= S_FIN;
        end
        S_FIN: begin
          done_q   <= 1'b1;
          status_q <= entry_verdict;
          if (l2_finish_ok) begin
            paddr_q <= {hi_q, vaddr_q[OFF_W-1:0]};
            flags_q <= mem_rdata;
          end else begin
            paddr_q <= '0;
            flags_q <= '0;
          end
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign done       = done_q;
  assign status     = status_q;
  assign paddr      = paddr_q;
  assign leaf_flags = flags_q;

  // ---------------- assertions ----------------
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (status != 2'd3));

  a_r4_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == ST_OK) |-> (paddr[OFF_W-1:0] == vaddr_q[OFF_W-1:0]));

  a_r4_ok_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == ST_OK) |-> leaf_flags[FLG_VALID]);

  a_r5_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status != ST_OK) |-> (paddr == '0 && leaf_flags == '0));

  a_r6_write_perm: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == ST_OK && wr_q) |-> leaf_flags[FLG_WRITE]);

  a_r7_user_perm: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == ST_OK && usr_q) |-> !leaf_flags[FLG_KERNEL]);

  a_r2_second_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && (state == S_L1_LO || state == S_L2_LO))
      |-> (mem_addr == $past(mem_addr) + PA_W'(1)));

  a_r10_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE) |=> $stable(vaddr_q));

endmodule

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_start = 1'b0;
  logic [23:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic [15:0] tbl_base = 16'h1000;
  logic        mem_rd_en;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic        done;
  logic [1:0]  status;
  logic [15:0] paddr;
  logic [7:0]  leaf_flags;

  always #2 clk = ~clk;

  pt_walker dut_i (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user), .tbl_base(tbl_base),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .done(done), .status(status), .paddr(paddr), .leaf_flags(leaf_flags)
  );

  // sparse byte memory
  logic [7:0] mem [int];
  function automatic logic [7:0] rd(input int a);
    int k;
    k = a & 32'hFFFF;
    return mem.exists(k) ? mem[k] : 8'h00;
  endfunction
  task automatic put16(input int a, input logic [15:0] v);
    mem[a & 32'hFFFF]       = v[15:8];
    mem[(a + 1) & 32'hFFFF] = v[7:0];
  endtask

  always @(posedge clk) if (mem_rd_en) mem_rdata <= rd(int'(mem_addr));

  int checks = 0;
  int fails = 0;
  string cur_tag = "R4";

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // reference model state
  int         m_cnt = 0;
  int         q_addr[$];
  logic [1:0] e_status;
  logic [15:0] e_paddr;
  logic [7:0] e_flags;

  function automatic int verdict(input logic [7:0] f, input bit w, input bit u);
    if (f[0] == 1'b0) return 1;
    if ((w && f[1] == 1'b0) || (u && f[7] == 1'b1)) return 2;
    return 0;
  endfunction

  task automatic model_start(input logic [23:0] va, input bit w, input bit u);
    int a1, a2, v;
    logic [15:0] ent;
    a1 = (int'(tbl_base) + 2 * int'(va[23:16])) & 32'hFFFF;
    q_addr.push_back(a1);
    q_addr.push_back((a1 + 1) & 32'hFFFF);
    ent = {rd(a1), rd(a1 + 1)};
    v = verdict(ent[7:0], w, u);
    if (v != 0) begin
      e_status = 2'(v); e_paddr = 0; e_flags = 0; m_cnt = 4;
      return;
    end
    a2 = (int'(ent[15:8]) * 256 + 2 * int'(va[15:8])) & 32'hFFFF;
    q_addr.push_back(a2);
    q_addr.push_back((a2 + 1) & 32'hFFFF);
    ent = {rd(a2), rd(a2 + 1)};
    v = verdict(ent[7:0], w, u);
    e_status = 2'(v);
    e_paddr  = (v == 0) ? {ent[15:8], va[7:0]} : 16'h0;
    e_flags  = (v == 0) ? ent[7:0] : 8'h0;
    m_cnt = 6;
  endtask

  // one cycle: compare at negedge, then drive
  task automatic step(input bit s, input logic [23:0] va, input bit w, input bit u);
    bit exp_done;
    @(negedge clk);
    exp_done = (m_cnt == 1);
    if (m_cnt > 0) m_cnt--;
    chk(done == exp_done, "R8", "done", done, exp_done);
    if (exp_done && done) begin
      chk(status == e_status, cur_tag, "status", status, e_status);
      chk(paddr == e_paddr, cur_tag, "paddr", paddr, e_paddr);
      chk(leaf_flags == e_flags, cur_tag, "leaf_flags", leaf_flags, e_flags);
    end
    if (mem_rd_en) begin
      if (q_addr.size() == 0)
        chk(1'b0, "R1,R3,R10", "unexpected read", mem_addr, 0);
      else begin
        int ea;
        ea = q_addr.pop_front();
        chk(int'(mem_addr) == ea, "R1,R3", "mem_addr", mem_addr, ea);
      end
    end
    req_start = s; req_vaddr = va; req_write = w; req_user = u;
    if (s && m_cnt == 0) model_start(va, w, u);
  endtask

  task automatic walk(input string tag, input logic [23:0] va, input bit w, input bit u);
    cur_tag = tag;
    step(1'b1, va, w, u);
    for (int i = 0; i < 7; i++) step(1'b0, va, w, u);
  endtask

  initial begin
    // table contents: L1 at 0x1000
    put16(32'h1000 + 2 * 8'h05, 16'h2003); // usable, writable
    put16(32'h1000 + 2 * 8'h07, 16'h2101); // read-only
    put16(32'h1000 + 2 * 8'h08, 16'h2283); // kernel-only
    put16(32'h1000 + 2 * 8'h09, 16'h2382); // kernel-only but invalid
    put16(32'h2000 + 2 * 8'h34, 16'h7C4F); // ok + uncacheable/dirty/use set
    put16(32'h2000 + 2 * 8'h35, 16'h7D01); // read-only leaf
    put16(32'h2000 + 2 * 8'h36, 16'h7E83); // kernel-only leaf
    put16(32'h2100 + 2 * 8'h00, 16'h5503);
    put16(32'h2200 + 2 * 8'h10, 16'h6603);

    repeat (3) @(negedge clk);
    // R11 reset state
    chk(done == 0 && status == 0, "R11", "done/status in reset", {done, status}, 0);
    chk(paddr == 0 && leaf_flags == 0, "R11", "paddr/flags in reset", {paddr, leaf_flags}, 0);
    chk(mem_rd_en == 0, "R11", "mem_rd_en in reset", mem_rd_en, 0);
    rst_n = 1'b1;
    step(1'b0, 24'h0, 1'b0, 1'b0);

    walk("R2,R4,R9", 24'h0534AB, 1'b0, 1'b1);
    walk("R4,R9", 24'h0534CD, 1'b1, 1'b1);
    walk("R5", 24'h0612EF, 1'b0, 1'b0);        // first-level invalid
    walk("R5", 24'h053701, 1'b0, 1'b0);        // second-level invalid
    walk("R6", 24'h053502, 1'b1, 1'b0);        // write to read-only leaf
    walk("R4", 24'h053503, 1'b0, 1'b0);        // read of same leaf
    walk("R6", 24'h070004, 1'b1, 1'b0);        // write, read-only first level
    walk("R3,R4", 24'h070005, 1'b0, 1'b0);
    walk("R7", 24'h053606, 1'b0, 1'b1);        // user to kernel leaf
    walk("R7", 24'h053607, 1'b1, 1'b0);        // kernel writes kernel leaf
    walk("R7", 24'h081008, 1'b0, 1'b1);        // user, kernel first level
    walk("R3,R7", 24'h081009, 1'b0, 1'b0);
    walk("R5,R7", 24'h09000A, 1'b0, 1'b1);     // invalid wins over kernel-only

    // R10: second start mid-walk is dropped
    cur_tag = "R10";
    step(1'b1, 24'h0534EE, 1'b0, 1'b0);
    step(1'b0, 24'h0534EE, 1'b0, 1'b0);
    step(1'b1, 24'h06FFFF, 1'b1, 1'b1);
    step(1'b1, 24'h0700AA, 1'b1, 1'b1);
    for (int i = 0; i < 8; i++) step(1'b0, 24'h0, 1'b0, 1'b0);
    chk(q_addr.size() == 0, "R10", "pending reads", q_addr.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule